// File: doc/BRIEF.md
# Quad-rail flit link receiver

This block is the receiving end of a link from a router output port. Each flit arrives as a quad-rail codeword: every two-bit digit position of the flit has four rails, and exactly one of them goes high to carry the digit's value. A separate end-of-frame wire marks a tail transfer. The link follows a four-phase return-to-spacer protocol. The sender raises a codeword and waits for the acknowledge. It then drops every rail back to zero and waits for the acknowledge to fall.

The receiver is clocked. It passes the rails and the end-of-frame wire through two-flop synchronizers. It waits until every digit position shows a rail and that state has held for two synchronized cycles. It then decodes each position to binary and works out from the packet position whether the flit is a head, a data or a tail flit. The flit is offered on a valid/ready port, with the coordinates pulled out of a head flit. The link is acknowledged only after the downstream port has taken the flit, so a downstream stall holds the remote sender.

Top module: `qrx_link_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fl_valid`, `ln_ack` and `err_seen` are 0 and `fl_kind` is 0.
- R2: A codeword is taken only when every digit position has at least one of its four rails high, or when `ln_eof` is high. A codeword with any position all-low is never delivered.
- R3: At position i, rail k alone high (rail k is `ln_r<k>`, k = 0..3) decodes to the value k. For a data flit that value is placed at `fl_data[2i+1:2i]`.
- R4: `fl_kind` is 1 (head) for the first flit after reset and the first flit after a tail, 3 (tail) whenever `ln_eof` is high, and 2 (data) otherwise. The end-of-frame wire takes precedence over head position. A tail has `fl_data`, `fl_x`, `fl_y` and `fl_bad` all zero, and the flit after it is again a head.
- R5: For a head flit, `fl_x` = {digit1, digit0} and `fl_y` = {digit3, digit2}. The payload digits 4 and upward are packed into `fl_data` starting at bit 0, and the top 8 bits of `fl_data` are zero. Data and tail flits report `fl_x` = `fl_y` = 0.
- R6: `fl_valid` rises on the 4th rising edge after a codeword appears at the pins. It then stays high, with its fields unchanged, until the edge at which `fl_ready` is high.
- R7: `ln_ack` rises on the edge after `fl_valid && fl_ready` and never while a flit is stalled. It stays high until all rails and `ln_eof` have returned to zero, and falls on the 3rd rising edge after that spacer reaches the pins. `fl_valid` and `ln_ack` are never high together.
- R8: A position whose pattern is not exactly one-hot decodes to digit 0. It sets `fl_bad` for that flit and sets `err_seen`, which stays 1 until reset.
- R9: A codeword that stays at the pins for only one clock cycle is dropped. It produces neither `fl_valid` nor `ln_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ln_r0 | input | NDIG | Rail 0 of every digit position (value 0) |
| ln_r1 | input | NDIG | Rail 1 of every digit position (value 1) |
| ln_r2 | input | NDIG | Rail 2 of every digit position (value 2) |
| ln_r3 | input | NDIG | Rail 3 of every digit position (value 3) |
| ln_eof | input | 1 | End-of-frame wire, high for a tail transfer |
| ln_ack | output | 1 | Four-phase acknowledge back to the sender |
| fl_valid | output | 1 | Decoded flit available |
| fl_ready | input | 1 | Downstream accepts the flit |
| fl_kind | output | 2 | 1 head, 2 data, 3 tail |
| fl_x | output | 4 | X coordinate of a head flit |
| fl_y | output | 4 | Y coordinate of a head flit |
| fl_data | output | 2*NDIG | Decoded payload |
| fl_bad | output | 1 | This flit contained an illegal digit pattern |
| err_seen | output | 1 | Sticky illegal-pattern flag |

## Verification
A codeword driven on a falling edge first shows on `fl_valid` at the fourth falling edge that follows: two synchronizer stages, one stability stage and the output register. `ln_ack` follows one edge after the downstream handshake. After the spacer is driven, `ln_ack` falls at the third falling edge. The directed checks wait exactly those counts and sample on the falling edge, and they also test the cycle just before, where the output must not have moved yet. Alongside them, a behavioural model steps on every rising edge from the same pin values and is compared with every output on every falling edge. Latency is therefore checked throughout: stalls, partial codewords and one-cycle glitches are covered as well as plain transfers.

// File: rtl/qrx_pkg.sv
package qrx_pkg;
  // number of rails carried per digit position
  localparam int QRX_RAILS = 4;
  // digits that form one coordinate
  localparam int QRX_COORD_DIG = 2;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_HEAD = 2'd1,
    K_DATA = 2'd2,
    K_TAIL = 2'd3
  } flit_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_DRAIN = 2'd2
  } rx_state_e;
endpackage

// File: rtl/qrx_sync.sv
module qrx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/qrx_digit_dec.sv
module qrx_digit_dec #(
  parameter int NDIG = 16
) (
  input  logic [NDIG-1:0]   r0_i,
  input  logic [NDIG-1:0]   r1_i,
  input  logic [NDIG-1:0]   r2_i,
  input  logic [NDIG-1:0]   r3_i,
  output logic [2*NDIG-1:0] dig_o,
  output logic [NDIG-1:0]   bad_o,
  output logic [NDIG-1:0]   hit_o
);
  for (genvar i = 0; i < NDIG; i++) begin : g_pos
    logic [3:0] q;
    logic [1:0] d;
    logic       b;

    assign q = {r3_i[i], r2_i[i], r1_i[i], r0_i[i]};

    always_comb begin
      b = 1'b0;
      case (q)
        4'b0001: d = 2'd0;
        4'b0010: d = 2'd1;
        4'b0100: d = 2'd2;
        4'b1000: d = 2'd3;
        default: begin
          d = 2'd0;
          b = 1'b1;
        end
      endcase
    end

    assign dig_o[2*i +: 2] = d;
    assign bad_o[i]        = b;
    assign hit_o[i]        = |q;
  end
endmodule

// File: rtl/qrx_ctrl.sv
module qrx_ctrl
  import qrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tok_i,
  input  logic       eof_i,
  input  logic       spacer_i,
  input  logic       ready_i,
  output logic       capture_o,
  output flit_kind_e cap_kind_o,
  output logic       valid_o,
  output logic       ack_o,
  output logic [1:0] kind_o
);
  rx_state_e  st_q;
  logic       tok_d_q;
  logic       head_next_q;
  flit_kind_e kind_q;

  always_comb begin
    capture_o = (st_q == ST_IDLE) && tok_i && tok_d_q;
    if (eof_i)            cap_kind_o = K_TAIL;
    else if (head_next_q) cap_kind_o = K_HEAD;
    else                  cap_kind_o = K_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      tok_d_q     <= 1'b0;
      head_next_q <= 1'b1;
      kind_q      <= K_NONE;
      valid_o     <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      tok_d_q <= tok_i;
      case (st_q)
        ST_IDLE: begin
          if (capture_o) begin
            valid_o     <= 1'b1;
            kind_q      <= cap_kind_o;
            head_next_q <= eof_i;
            st_q        <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (ready_i) begin
            valid_o <= 1'b0;
            ack_o   <= 1'b1;
            st_q    <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (spacer_i) begin
            ack_o <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign kind_o = kind_q;

  // R7
  ack_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ack_o));

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i |=> valid_o && $stable(kind_o));

  // R7
  ack_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(valid_o && ready_i));

  // R7
  ack_drop_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(spacer_i));
endmodule

// File: rtl/qrx_link_rx.sv
module qrx_link_rx
  import qrx_pkg::*;
#(
  parameter int NDIG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NDIG-1:0]   ln_r0,
  input  logic [NDIG-1:0]   ln_r1,
  input  logic [NDIG-1:0]   ln_r2,
  input  logic [NDIG-1:0]   ln_r3,
  input  logic              ln_eof,
  output logic              ln_ack,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [1:0]        fl_kind,
  output logic [3:0]        fl_x,
  output logic [3:0]        fl_y,
  output logic [2*NDIG-1:0] fl_data,
  output logic              fl_bad,
  output logic              err_seen
);
  localparam int PW = 2 * NDIG;
  localparam int CW = 2 * QRX_COORD_DIG;
  localparam int IW = QRX_RAILS * NDIG + 1;

  logic [IW-1:0]   sync_q;
  logic [NDIG-1:0] s_r0, s_r1, s_r2, s_r3;
  logic            s_eof;
  logic [PW-1:0]   dig;
  logic [NDIG-1:0] bad_pos;
  logic [NDIG-1:0] hit;
  logic            tok;
  logic            spacer;
  logic            capture;
  flit_kind_e      cap_kind;

  qrx_sync #(.W(IW)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ln_eof, ln_r3, ln_r2, ln_r1, ln_r0}),
    .q_o (sync_q)
  );

  assign {s_eof, s_r3, s_r2, s_r1, s_r0} = sync_q;

  qrx_digit_dec #(.NDIG(NDIG)) i_dec (
    .r0_i  (s_r0),
    .r1_i  (s_r1),
    .r2_i  (s_r2),
    .r3_i  (s_r3),
    .dig_o (dig),
    .bad_o (bad_pos),
    .hit_o (hit)
  );

  assign tok    = (&hit) | s_eof;
  assign spacer = ~|sync_q;

  qrx_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tok_i      (tok),
    .eof_i      (s_eof),
    .spacer_i   (spacer),
    .ready_i    (fl_ready),
    .capture_o  (capture),
    .cap_kind_o (cap_kind),
    .valid_o    (fl_valid),
    .ack_o      (ln_ack),
    .kind_o     (fl_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_x     <= '0;
      fl_y     <= '0;
      fl_data  <= '0;
      fl_bad   <= 1'b0;
      err_seen <= 1'b0;
    end else if (capture) begin
      case (cap_kind)
        K_HEAD: begin
          fl_x    <= dig[CW-1:0];
          fl_y    <= dig[2*CW-1:CW];
          fl_data <= dig >> (2 * CW);
          fl_bad  <= |bad_pos;
        end
        K_DATA: begin
          fl_x    <= '0;
          fl_y    <= '0;
          fl_data <= dig;
          fl_bad  <= |bad_pos;
        end
        default: begin
          fl_x    <= '0;
          fl_y    <= '0;
          fl_data <= '0;
          fl_bad  <= 1'b0;
        end
      endcase
      if (cap_kind != K_TAIL && (|bad_pos)) err_seen <= 1'b1;
    end
  end

  // R4
  tail_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fl_valid && fl_kind == 2'd3 |-> fl_data == '0 && !fl_bad);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_seen |=> err_seen);
endmodule

// File: tb/test_qrx_link_rx.sv
`timescale 1ns/1ps
module test_qrx_link_rx;
  localparam int NDIG = 16;
  localparam int PW   = 2 * NDIG;
  localparam int IW   = 4 * NDIG + 1;
  localparam int RW   = 4 * NDIG;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NDIG-1:0] ln_r0 = '0, ln_r1 = '0, ln_r2 = '0, ln_r3 = '0;
  logic            ln_eof = 1'b0;
  logic            ln_ack;
  logic            fl_valid;
  logic            fl_ready = 1'b0;
  logic [1:0]      fl_kind;
  logic [3:0]      fl_x, fl_y;
  logic [PW-1:0]   fl_data;
  logic            fl_bad;
  logic            err_seen;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  bit started = 0;

  always #10 clk = ~clk;

  qrx_link_rx #(.NDIG(NDIG)) i_qrx_link_rx (
    .clk(clk), .rst(rst),
    .ln_r0(ln_r0), .ln_r1(ln_r1), .ln_r2(ln_r2), .ln_r3(ln_r3),
    .ln_eof(ln_eof), .ln_ack(ln_ack),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_kind(fl_kind),
    .fl_x(fl_x), .fl_y(fl_y), .fl_data(fl_data),
    .fl_bad(fl_bad), .err_seen(err_seen)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [IW-1:0] m1, m2;
  bit            mtd, mv, mack, mhn, merr, mbad;
  int            mst;
  logic [1:0]    mk;
  logic [3:0]    mx, my;
  logic [PW-1:0] md;
  bit            e_tk, e_sp, e_bb;
  logic [PW-1:0] e_dv;

  function automatic void meval(input logic [IW-1:0] s, output bit tk, output bit sp,
                                output logic [PW-1:0] dv, output bit bb);
    tk = 1; sp = (s == '0); dv = '0; bb = 0;
    for (int i = 0; i < NDIG; i++) begin
      int n;
      int val;
      n = 0; val = 0;
      for (int k = 0; k < 4; k++) if (s[k*NDIG+i]) begin n++; val = k; end
      if (n == 0) tk = 0;
      if (n != 1) bb = 1;
      else dv[2*i +: 2] = 2'(val);
    end
    if (s[IW-1]) tk = 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m1 = '0; m2 = '0; mtd = 0; mv = 0; mack = 0; mhn = 1; merr = 0; mbad = 0;
      mst = 0; mk = 0; mx = 0; my = 0; md = '0;
    end else begin
      meval(m2, e_tk, e_sp, e_dv, e_bb);
      case (mst)
        0: if (e_tk && mtd) begin
             mv = 1; mst = 1;
             if (m2[IW-1]) begin
               mk = 3; mx = 0; my = 0; md = '0; mbad = 0; mhn = 1;
             end else begin
               if (mhn) begin
                 mk = 1; mx = e_dv[3:0]; my = e_dv[7:4]; md = e_dv >> 8;
               end else begin
                 mk = 2; mx = 0; my = 0; md = e_dv;
               end
               mbad = e_bb;
               if (e_bb) merr = 1;
               mhn = 0;
             end
           end
        1: if (fl_ready) begin mv = 0; mack = 1; mst = 2; end
        default: if (e_sp) begin mack = 0; mst = 0; end
      endcase
      mtd = e_tk;
      m2  = m1;
      m1  = {ln_eof, ln_r3, ln_r2, ln_r1, ln_r0};
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(fl_valid == mv, "R6 model valid", fl_valid, mv);
      chk(ln_ack == mack, "R7 model ack", ln_ack, mack);
      chk(err_seen == merr, "R8 model err", err_seen, merr);
      if (mv) begin
        chk(fl_kind == mk, "R4 model kind", fl_kind, mk);
        chk(fl_data == md, "R3 model data", fl_data, md);
        chk({fl_y, fl_x} == {my, mx}, "R5 model coords", {fl_y, fl_x}, {my, mx});
        chk(fl_bad == mbad, "R8 model bad", fl_bad, mbad);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [RW-1:0] enc(input logic [PW-1:0] v);
    logic [RW-1:0] r;
    r = '0;
    for (int i = 0; i < NDIG; i++) r[int'(v[2*i +: 2]) * NDIG + i] = 1'b1;
    return r;
  endfunction

  task automatic put(input logic [RW-1:0] r, input logic e);
    {ln_r3, ln_r2, ln_r1, ln_r0} = r;
    ln_eof = e;
  endtask

  logic [1:0]    g_kind;
  logic [3:0]    g_x, g_y;
  logic [PW-1:0] g_data;
  logic          g_bad;

  // drive one codeword, take it downstream, return to spacer
  task automatic flit(input logic [RW-1:0] r, input logic e);
    @(negedge clk);
    put(r, e);
    do @(negedge clk); while (!fl_valid);
    g_kind = fl_kind; g_x = fl_x; g_y = fl_y; g_data = fl_data; g_bad = fl_bad;
    do @(negedge clk); while (!ln_ack);
    put('0, 1'b0);
    do @(negedge clk); while (ln_ack);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [PW-1:0] v;
  logic [RW-1:0] r;
  int k2;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(fl_valid == 0 && ln_ack == 0, "R1 reset valid/ack", {fl_valid, ln_ack}, 0);
    chk(err_seen == 0 && fl_kind == 0, "R1 reset err/kind", {err_seen, fl_kind}, 0);

    // head flit with exact latency (R6), coordinates (R5)
    fl_ready = 1'b1;
    v = {24'hBEEF42, 4'hA, 4'h5};
    put(enc(v), 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk(fl_valid == 0, "R6 valid not early", fl_valid, 0);
    end
    @(negedge clk);
    chk(fl_valid == 1, "R6 valid on 4th edge", fl_valid, 1);
    chk(fl_kind == 1, "R4 first flit is head", fl_kind, 1);
    chk(fl_x == 4'h5, "R5 head x", fl_x, 5);
    chk(fl_y == 4'hA, "R5 head y", fl_y, 4'hA);
    chk(fl_data == 32'h00BEEF42, "R5 head payload", fl_data, 32'h00BEEF42);
    @(negedge clk);
    chk(ln_ack == 1 && fl_valid == 0, "R7 ack after take", {ln_ack, fl_valid}, 2'b10);
    put('0, 1'b0);
    repeat (2) begin
      @(negedge clk);
      chk(ln_ack == 1, "R7 ack held until spacer synced", ln_ack, 1);
    end
    @(negedge clk);
    chk(ln_ack == 0, "R7 ack falls 3rd edge", ln_ack, 0);

    // data flit with downstream stall (R3, R7)
    fl_ready = 1'b0;
    v = 32'hC3A50F96;
    @(negedge clk);
    put(enc(v), 1'b0);
    do @(negedge clk); while (!fl_valid);
    chk(fl_kind == 2, "R4 second flit is data", fl_kind, 2);
    chk(fl_data == v, "R3 data decode", fl_data, v);
    repeat (6) begin
      @(negedge clk);
      chk(fl_valid == 1 && ln_ack == 0, "R7 no ack while stalled", {fl_valid, ln_ack}, 2'b10);
    end
    fl_ready = 1'b1;
    @(negedge clk);
    chk(ln_ack == 1, "R7 ack after release", ln_ack, 1);
    put('0, 1'b0);
    do @(negedge clk); while (ln_ack);

    // tail, then tail again with head pending (R4)
    flit('0, 1'b1);
    chk(g_kind == 3, "R4 eof gives tail", g_kind, 3);
    chk(g_data == 0 && g_x == 0 && g_y == 0, "R4 tail empty", g_data, 0);
    flit(enc(32'h12345678), 1'b1);
    chk(g_kind == 3, "R4 eof beats head position", g_kind, 3);
    flit(enc({24'h0, 4'h3, 4'hC}), 1'b0);
    chk(g_kind == 1, "R4 head after tail", g_kind, 1);
    chk(g_x == 4'hC && g_y == 4'h3, "R5 head coords again", {g_y, g_x}, 8'h3C);

    // illegal pattern at position 2 (R8)
    v = 32'h12345678;
    r = enc(v);
    k2 = int'(v[5:4]);
    r[((k2 + 1) % 4) * NDIG + 2] = 1'b1;
    flit(r, 1'b0);
    chk(g_bad == 1, "R8 bad flag", g_bad, 1);
    chk(g_data == (v & ~32'h30), "R8 illegal digit zero", g_data, v & ~32'h30);
    chk(err_seen == 1, "R8 sticky set", err_seen, 1);
    flit(enc(32'h0F0F0F0F), 1'b0);
    chk(g_bad == 0 && g_data == 32'h0F0F0F0F, "R8 clean flit", g_data, 32'h0F0F0F0F);
    chk(err_seen == 1, "R8 sticky held", err_seen, 1);

    // partial codeword (R2)
    v = 32'hFFFF0000;
    r = enc(v);
    for (int k = 0; k < 4; k++) r[k * NDIG + 7] = 1'b0;
    @(negedge clk);
    put(r, 1'b0);
    repeat (12) @(negedge clk);
    chk(fl_valid == 0 && ln_ack == 0, "R2 partial not taken", fl_valid, 0);
    put(enc(v), 1'b0);
    do @(negedge clk); while (!fl_valid);
    chk(fl_data == v && fl_kind == 2, "R2 completed codeword taken", fl_data, v);
    do @(negedge clk); while (!ln_ack);
    put('0, 1'b0);
    do @(negedge clk); while (ln_ack);

    // one-cycle glitch (R9)
    @(negedge clk);
    put(enc(32'hAAAA5555), 1'b0);
    @(negedge clk);
    put('0, 1'b0);
    repeat (8) @(negedge clk);
    chk(fl_valid == 0 && ln_ack == 0, "R9 glitch dropped", {fl_valid, ln_ack}, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule